// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block runs complete page read, page program and block erase operations on a raw 8-bit NAND flash bus. A host hands it one request at a time through a start/busy/done handshake. Each request carries an operation code, a row (page) number and a byte column. The sequencer emits the command bytes, address bytes and data bytes with command-latch, address-latch and write-enable strobes. It streams program data in from a first-word-fall-through byte source, streams read data out to a byte sink, and then polls the device status until the device reports ready or a poll budget runs out.

Program and erase first confirm that the device is idle. If it stays busy through a full poll budget, the block sends a device reset and checks once more. Requests that are misaligned or malformed are refused at once, with no bus activity. Chip-enable is held low for the whole of an accepted operation and is released only when the result is reported.

Top module: `nand_op_seq`

## Requirements
- R1: A request is rejected when it is an erase whose page is not a multiple of PAGES_PER_BLOCK or whose column is not zero, a program whose column is not zero, a read whose column is not below DATA_BYTES+SPARE_BYTES, or any request with op code 3. A rejected request gets result 3 with a one-cycle done pulse, and chip-enable never goes low.
- R2: A read (op 0) sends command 0x00, then five address bytes (column bits 7:0, column bits 15:8, page bits 7:0, 15:8, 23:16), then 0x30. It then polls status, re-issues 0x00 once the device is ready, and delivers bytes DATA_BYTES+SPARE_BYTES-col in column order on the read port.
- R3: A program (op 1) sends 0x80 and five address bytes with both column bytes zero. It then sends DATA_BYTES+SPARE_BYTES data bytes taken in order from the write port, followed by 0x10.
- R4: An erase (op 2) sends 0x60, three row bytes (page bits 7:0, 15:8, 23:16) and then 0xD0.
- R5: After the confirm command the block sends status command 0x70 and reads status bytes, waiting POLL_GAP idle cycles between reads. Bit 6 set means ready. For program and erase, a ready status with bit 0 set yields result 1; otherwise the result is 0. done_o pulses for one cycle.
- R6: If POLL_MAX status reads in a row lack the ready bit, the operation ends with result 2 and no further bus cycle.
- R7: Before program or erase, the block sends 0x70 and polls for ready. After POLL_MAX busy reads it sends 0xFF and polls again. If the second check also fails, the result is 2 and no program or erase command is sent.
- R8: Command cycles have CLE high and ALE low. Address cycles have ALE high and CLE low. Data cycles have both low. Write and read strobes are never low together, and each strobe stays low for exactly STROBE_CYC clocks.
- R9: Chip-enable is low exactly while busy_o is high. A start pulse that arrives while busy has no effect.
- R10: Program data is not strobed while the write source is empty. Read data is not strobed while the read sink is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, sampled only when idle |
| op_i | input | 2 | 0 read, 1 program, 2 erase, 3 invalid |
| page_i | input | ROW_W | Page (row) number |
| col_i | input | COL_W | Byte column |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 0 ok, 1 device fail, 2 timeout, 3 rejected |
| wr_data_i | input | 8 | Head byte of program data source |
| wr_empty_i | input | 1 | Program data source empty |
| wr_pop_o | output | 1 | Consume head byte of program source |
| rd_data_o | output | 8 | Read data byte |
| rd_push_o | output | 1 | rd_data_o valid, push into sink |
| rd_full_i | input | 1 | Read sink full |
| nand_ce_no | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Bus data out |
| nand_dq_oe_o | output | 1 | Bus output enable |
| nand_dq_i | input | 8 | Bus data in |

## Verification
The assertions check the bus-level rules on every cycle: CLE and ALE are exclusive, write and read strobes never overlap, strobe width is exact, chip-enable is low whenever a strobe is low, rejection keeps the bus quiet, poll counters stay bounded, and a stalled sink holds the read strobe high. Only the bench's scenarios, with a device model that logs every latched byte, can show the actual command and address byte order, the column forcing on program, the order of streamed data, the reset-and-retry path, and the chosen result codes for pass, fail and timeout.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {CYC_CMD, CYC_ADDR, CYC_DWR, CYC_DRD} cyc_kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PCHK_CMD, S_PCHK_RD, S_PCHK_GAP, S_PCHK_RST,
    S_CMD1, S_ADDR, S_WDATA, S_CMD2,
    S_POLL_CMD, S_POLL_RD, S_POLL_GAP, S_RD_CMD, S_RDATA
  } seq_state_e;

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_PROG  = 2'd1;
  localparam logic [1:0] OP_ERASE = 2'd2;

  localparam logic [1:0] RES_OK   = 2'd0;
  localparam logic [1:0] RES_FAIL = 2'd1;
  localparam logic [1:0] RES_TMO  = 2'd2;
  localparam logic [1:0] RES_REJ  = 2'd3;

  localparam logic [7:0] CMD_RD_SETUP = 8'h00;
  localparam logic [7:0] CMD_RD_GO    = 8'h30;
  localparam logic [7:0] CMD_PG_SETUP = 8'h80;
  localparam logic [7:0] CMD_PG_GO    = 8'h10;
  localparam logic [7:0] CMD_ER_SETUP = 8'h60;
  localparam logic [7:0] CMD_ER_GO    = 8'hD0;
  localparam logic [7:0] CMD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_RESET    = 8'hFF;

  localparam int STAT_RDY_BIT  = 6;
  localparam int STAT_FAIL_BIT = 0;

endpackage

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle
  import nand_seq_pkg::*;
#(
  parameter int STROBE_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  cyc_kind_e  kind_i,
  input  logic [7:0] byte_i,
  output logic       idle_o,
  output logic       done_o,
  output logic [7:0] rd_byte_o,
  output logic       cle_o,
  output logic       ale_o,
  output logic       we_no,
  output logic       re_no,
  output logic       dq_oe_o,
  output logic [7:0] dq_o,
  input  logic [7:0] dq_i
);
  localparam int CW = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(STROBE_CYC - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_e;
  phase_e ph_q;
  logic [CW-1:0] cnt_q;

  assign idle_o = (ph_q == PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      done_o    <= 1'b0;
      rd_byte_o <= '0;
      cle_o     <= 1'b0;
      ale_o     <= 1'b0;
      we_no     <= 1'b1;
      re_no     <= 1'b1;
      dq_oe_o   <= 1'b0;
      dq_o      <= '0;
    end else begin
      done_o <= 1'b0;
      case (ph_q)
        PH_IDLE: if (go_i) begin
          ph_q    <= PH_LOW;
          cnt_q   <= '0;
          cle_o   <= (kind_i == CYC_CMD);
          ale_o   <= (kind_i == CYC_ADDR);
          dq_oe_o <= (kind_i != CYC_DRD);
          dq_o    <= (kind_i == CYC_DRD) ? 8'h00 : byte_i;
          we_no   <= (kind_i == CYC_DRD);
          re_no   <= (kind_i != CYC_DRD);
        end
        PH_LOW: begin
          if (cnt_q == LAST) begin
            ph_q  <= PH_HIGH;
            cnt_q <= '0;
            we_no <= 1'b1;
            re_no <= 1'b1;
            if (!re_no) rd_byte_o <= dq_i;  // sample just before release
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_HIGH: begin
          if (cnt_q == LAST) begin
            ph_q    <= PH_IDLE;
            done_o  <= 1'b1;
            cle_o   <= 1'b0;
            ale_o   <= 1'b0;
            dq_oe_o <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  // strobe low-time monitor
  logic [CW:0] chk_low_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_low_q <= '0;
    else if (!we_no || !re_no) chk_low_q <= chk_low_q + 1'b1;
    else chk_low_q <= '0;
  end

  assert_strobe_width_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(we_no) || $rose(re_no)) |-> chk_low_q == (CW+1)'(STROBE_CYC));
  assert_latch_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));
  assert_strobe_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !re_no));
  assert_we_drives_bus_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> dq_oe_o);

endmodule

// File: rtl/nand_gap_timer.sv
module nand_gap_timer #(
  parameter int GAP_CYC = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expire_o
);
  localparam int GW = $clog2(GAP_CYC + 1);

  logic [GW-1:0] cnt_q;
  logic          run_q;

  assign expire_o = run_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= GW'(GAP_CYC - 1);
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/nand_req_check.sv
module nand_req_check
  import nand_seq_pkg::*;
#(
  parameter int DATA_BYTES      = 2048,
  parameter int SPARE_BYTES     = 64,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int ROW_W           = 24,
  parameter int COL_W           = 12
) (
  input  logic [1:0]       op_i,
  input  logic [ROW_W-1:0] page_i,
  input  logic [COL_W-1:0] col_i,
  output logic             valid_o
);
  localparam int TOTAL = DATA_BYTES + SPARE_BYTES;

  logic blk_aligned;
  assign blk_aligned = ((page_i % ROW_W'(PAGES_PER_BLOCK)) == '0);

  always_comb begin
    case (op_i)
      OP_READ:  valid_o = (32'(col_i) < 32'(TOTAL));
      OP_PROG:  valid_o = (col_i == '0);
      OP_ERASE: valid_o = (col_i == '0) && blk_aligned;
      default:  valid_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
  import nand_seq_pkg::*;
#(
  parameter int DATA_BYTES      = 2048,
  parameter int SPARE_BYTES     = 64,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int ROW_W           = 24,
  parameter int COL_W           = 12,
  parameter int POLL_MAX        = 100,
  parameter int POLL_GAP        = 50,
  parameter int STROBE_CYC      = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [ROW_W-1:0] page_i,
  input  logic [COL_W-1:0] col_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [1:0]       result_o,
  input  logic [7:0]       wr_data_i,
  input  logic             wr_empty_i,
  output logic             wr_pop_o,
  output logic [7:0]       rd_data_o,
  output logic             rd_push_o,
  input  logic             rd_full_i,
  output logic             nand_ce_no,
  output logic             nand_cle_o,
  output logic             nand_ale_o,
  output logic             nand_we_no,
  output logic             nand_re_no,
  output logic [7:0]       nand_dq_o,
  output logic             nand_dq_oe_o,
  input  logic [7:0]       nand_dq_i
);
  localparam int TOTAL = DATA_BYTES + SPARE_BYTES;
  localparam int CNT_W = $clog2(TOTAL);
  localparam int PW    = $clog2(POLL_MAX + 1);

  seq_state_e       state_q;
  logic [1:0]       op_q;
  logic [ROW_W-1:0] page_q;
  logic [COL_W-1:0] col_q;
  logic [2:0]       addr_idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PW-1:0]    poll_q;
  logic             rst_tried_q;
  logic             done_q;
  logic [1:0]       res_q;

  logic       req_ok;
  logic       eng_go, eng_idle, eng_done;
  cyc_kind_e  eng_kind;
  logic [7:0] eng_byte, eng_rd;
  logic       gap_start, gap_exp;
  logic       can_go, stat_rdy, poll_last, wr_last, rd_last;
  logic [23:0] row24;
  logic [15:0] col16;
  logic [7:0]  addr_byte, cmd_setup, cmd_go;

  nand_req_check #(
    .DATA_BYTES(DATA_BYTES), .SPARE_BYTES(SPARE_BYTES),
    .PAGES_PER_BLOCK(PAGES_PER_BLOCK), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_chk (.op_i(op_i), .page_i(page_i), .col_i(col_i), .valid_o(req_ok));

  nand_bus_cycle #(.STROBE_CYC(STROBE_CYC)) u_bus (
    .clk_i(clk_i), .rst_ni(rst_ni), .go_i(eng_go), .kind_i(eng_kind),
    .byte_i(eng_byte), .idle_o(eng_idle), .done_o(eng_done), .rd_byte_o(eng_rd),
    .cle_o(nand_cle_o), .ale_o(nand_ale_o), .we_no(nand_we_no), .re_no(nand_re_no),
    .dq_oe_o(nand_dq_oe_o), .dq_o(nand_dq_o), .dq_i(nand_dq_i)
  );

  nand_gap_timer #(.GAP_CYC(POLL_GAP)) u_gap (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(gap_start), .expire_o(gap_exp)
  );

  assign busy_o     = (state_q != S_IDLE);
  assign nand_ce_no = (state_q == S_IDLE);
  assign done_o     = done_q;
  assign result_o   = res_q;
  assign rd_data_o  = eng_rd;
  assign rd_push_o  = (state_q == S_RDATA) && eng_done;

  assign can_go    = eng_idle && !eng_done;
  assign stat_rdy  = eng_rd[STAT_RDY_BIT];
  assign poll_last = (poll_q == PW'(POLL_MAX - 1));
  assign wr_last   = (cnt_q == CNT_W'(TOTAL - 1));
  assign rd_last   = ((32'(cnt_q) + 32'(col_q)) == 32'(TOTAL - 1));
  assign row24     = 24'(page_q);
  assign col16     = 16'(col_q);
  assign gap_start = ((state_q == S_PCHK_RD) || (state_q == S_POLL_RD)) &&
                     eng_done && !stat_rdy && !poll_last;

  always_comb begin
    case (addr_idx_q)
      3'd0:    addr_byte = col16[7:0];
      3'd1:    addr_byte = col16[15:8];
      3'd2:    addr_byte = row24[7:0];
      3'd3:    addr_byte = row24[15:8];
      default: addr_byte = row24[23:16];
    endcase
    case (op_q)
      OP_PROG:  begin cmd_setup = CMD_PG_SETUP; cmd_go = CMD_PG_GO; end
      OP_ERASE: begin cmd_setup = CMD_ER_SETUP; cmd_go = CMD_ER_GO; end
      default:  begin cmd_setup = CMD_RD_SETUP; cmd_go = CMD_RD_GO; end
    endcase
  end

  always_comb begin
    eng_go   = 1'b0;
    eng_kind = CYC_CMD;
    eng_byte = 8'h00;
    wr_pop_o = 1'b0;
    case (state_q)
      S_PCHK_CMD, S_POLL_CMD: begin eng_go = can_go; eng_byte = CMD_STATUS; end
      S_PCHK_RST: begin eng_go = can_go; eng_byte = CMD_RESET; end
      S_CMD1:     begin eng_go = can_go; eng_byte = cmd_setup; end
      S_CMD2:     begin eng_go = can_go; eng_byte = cmd_go; end
      S_RD_CMD:   begin eng_go = can_go; eng_byte = CMD_RD_SETUP; end
      S_ADDR: begin
        eng_go = can_go; eng_kind = CYC_ADDR; eng_byte = addr_byte;
      end
      S_WDATA: begin
        eng_go   = can_go && !wr_empty_i;
        eng_kind = CYC_DWR;
        eng_byte = wr_data_i;
        wr_pop_o = eng_go;
      end
      S_PCHK_RD, S_POLL_RD: begin eng_go = can_go; eng_kind = CYC_DRD; end
      S_RDATA: begin eng_go = can_go && !rd_full_i; eng_kind = CYC_DRD; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      op_q        <= OP_READ;
      page_q      <= '0;
      col_q       <= '0;
      addr_idx_q  <= '0;
      cnt_q       <= '0;
      poll_q      <= '0;
      rst_tried_q <= 1'b0;
      done_q      <= 1'b0;
      res_q       <= RES_OK;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        S_IDLE: if (start_i) begin
          if (req_ok) begin
            op_q        <= op_i;
            page_q      <= page_i;
            col_q       <= (op_i == OP_READ) ? col_i : '0;
            addr_idx_q  <= (op_i == OP_ERASE) ? 3'd2 : 3'd0;
            poll_q      <= '0;
            rst_tried_q <= 1'b0;
            state_q     <= (op_i == OP_READ) ? S_CMD1 : S_PCHK_CMD;
          end else begin
            done_q <= 1'b1;
            res_q  <= RES_REJ;
          end
        end
        S_PCHK_CMD: if (eng_done) state_q <= S_PCHK_RD;
        S_PCHK_RD: if (eng_done) begin
          if (stat_rdy) state_q <= S_CMD1;
          else if (poll_last) begin
            poll_q <= '0;
            if (rst_tried_q) begin
              state_q <= S_IDLE; done_q <= 1'b1; res_q <= RES_TMO;
            end else state_q <= S_PCHK_RST;
          end else begin
            poll_q  <= poll_q + 1'b1;
            state_q <= S_PCHK_GAP;
          end
        end
        S_PCHK_GAP: if (gap_exp) state_q <= S_PCHK_RD;
        S_PCHK_RST: if (eng_done) begin
          rst_tried_q <= 1'b1;
          state_q     <= S_PCHK_CMD;
        end
        S_CMD1: if (eng_done) state_q <= S_ADDR;
        S_ADDR: if (eng_done) begin
          if (addr_idx_q == 3'd4) begin
            cnt_q   <= '0;
            state_q <= (op_q == OP_PROG) ? S_WDATA : S_CMD2;
          end else addr_idx_q <= addr_idx_q + 1'b1;
        end
        S_WDATA: if (eng_done) begin
          if (wr_last) state_q <= S_CMD2;
          else cnt_q <= cnt_q + 1'b1;
        end
        S_CMD2: if (eng_done) begin
          poll_q  <= '0;
          state_q <= S_POLL_CMD;
        end
        S_POLL_CMD: if (eng_done) state_q <= S_POLL_RD;
        S_POLL_RD: if (eng_done) begin
          if (stat_rdy) begin
            if (op_q == OP_READ) begin
              cnt_q   <= '0;
              state_q <= S_RD_CMD;
            end else begin
              state_q <= S_IDLE;
              done_q  <= 1'b1;
              res_q   <= eng_rd[STAT_FAIL_BIT] ? RES_FAIL : RES_OK;
            end
          end else if (poll_last) begin
            state_q <= S_IDLE; done_q <= 1'b1; res_q <= RES_TMO;
          end else begin
            poll_q  <= poll_q + 1'b1;
            state_q <= S_POLL_GAP;
          end
        end
        S_POLL_GAP: if (gap_exp) state_q <= S_POLL_RD;
        S_RD_CMD: if (eng_done) state_q <= S_RDATA;
        S_RDATA: if (eng_done) begin
          if (rd_last) begin
            state_q <= S_IDLE; done_q <= 1'b1; res_q <= RES_OK;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_strobe_in_ce_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no || !nand_re_no) |-> !nand_ce_no);
  assert_reject_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && res_q == RES_REJ) |-> (nand_ce_no && $past(nand_ce_no)));
  assert_poll_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_POLL_RD || state_q == S_PCHK_RD) |-> poll_q < PW'(POLL_MAX));
  assert_pop_strobes_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pop_o |=> (!nand_we_no && !nand_cle_o && !nand_ale_o));
  assert_rd_stall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RDATA && rd_full_i && can_go) |=> nand_re_no);

endmodule

// File: tb/nand_op_seq_bench.sv
module nand_op_seq_bench;
  localparam int DB = 16, SB = 4, PPB = 4, PMAX = 5, PGAP = 3, STRB = 2;
  localparam int TOT = DB + SB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic start = 1'b0;
  logic [1:0] op = 2'd0;
  logic [23:0] page = '0;
  logic [11:0] col = '0;
  logic busy, done, wr_pop, rd_push, ce_n, cle, ale, we_n, re_n, dq_oe;
  logic [1:0] result;
  logic [7:0] rd_data, dq_o, dq_i, wr_data;
  logic wr_empty, rd_full = 1'b0;

  nand_op_seq #(.DATA_BYTES(DB), .SPARE_BYTES(SB), .PAGES_PER_BLOCK(PPB),
    .ROW_W(24), .COL_W(12), .POLL_MAX(PMAX), .POLL_GAP(PGAP), .STROBE_CYC(STRB))
  u_nand_op_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .page_i(page),
    .col_i(col), .busy_o(busy), .done_o(done), .result_o(result),
    .wr_data_i(wr_data), .wr_empty_i(wr_empty), .wr_pop_o(wr_pop),
    .rd_data_o(rd_data), .rd_push_o(rd_push), .rd_full_i(rd_full),
    .nand_ce_no(ce_n), .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_no(we_n),
    .nand_re_no(re_n), .nand_dq_o(dq_o), .nand_dq_oe_o(dq_oe), .nand_dq_i(dq_i));

  int checks = 0, errors = 0;

  // write source
  logic [7:0] wq [0:255];
  int wq_rd = 0, wq_n = 0;
  assign wr_empty = (wq_rd >= wq_n);
  assign wr_data  = wq[wq_rd[7:0]];
  always @(posedge clk) if (wr_pop) wq_rd <= wq_rd + 1;

  // read sink
  logic [7:0] rq [0:255];
  int rq_n = 0;
  always @(posedge clk) if (rd_push) begin rq[rq_n[7:0]] <= rd_data; rq_n <= rq_n + 1; end

  // device model
  logic [7:0] log_b [0:1023];
  int log_k [0:1023];
  int log_n = 0, busy_left = 0, op_busy = 0, idx = 0, addr_cnt = 0, re_stat = 0;
  logic [15:0] col_lat = '0;
  logic stat_mode = 1'b0, fail_flag = 1'b0;

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 13) + 8'h5A);
  endfunction

  assign dq_i = stat_mode ? {1'b1, (busy_left == 0), 5'b0, fail_flag} : pat(idx);

  always @(posedge we_n) if (!ce_n) begin
    log_b[log_n[9:0]] = dq_o;
    log_k[log_n[9:0]] = (cle && ale) ? 3 : cle ? 0 : ale ? 1 : 2;
    log_n++;
    if (cle) begin
      addr_cnt = 0;
      if (dq_o == 8'h70) stat_mode = 1'b1;
      if (dq_o == 8'h00) begin stat_mode = 1'b0; idx = int'(col_lat); end
      if (dq_o == 8'h30 || dq_o == 8'h10 || dq_o == 8'hD0) busy_left = op_busy;
    end else if (ale) begin
      if (addr_cnt == 0) col_lat[7:0] = dq_o;
      if (addr_cnt == 1) col_lat[15:8] = dq_o;
      addr_cnt++;
    end
  end

  always @(posedge re_n) if (!ce_n) begin
    if (stat_mode) begin re_stat++; if (busy_left > 0) busy_left--; end
    else idx++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_log(input int i, input int k, input int b, input string req);
    chk(log_k[i[9:0]] == k && log_b[i[9:0]] == 8'(b), req, $sformatf("bus byte %0d", i),
        log_k[i[9:0]] * 256 + int'(log_b[i[9:0]]), k * 256 + b);
  endtask

  task automatic issue(input logic [1:0] o, input logic [23:0] p, input logic [11:0] c);
    @(negedge clk);
    op = o; page = p; col = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int res);
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    res = int'(result);
    if (n >= 20000) chk(1'b0, "R5", "done timeout", 0, 1);
  endtask

  task automatic t_reset();
    chk(ce_n === 1'b1 && busy === 1'b0 && done === 1'b0, "R9", "reset ce/busy/done",
        {ce_n, busy, done}, 3'b100);
    chk(we_n === 1'b1 && re_n === 1'b1 && cle === 1'b0 && ale === 1'b0, "R8",
        "reset strobes", {we_n, re_n, cle, ale}, 4'b1100);
  endtask

  task automatic t_read();
    int b = log_n, r0 = rq_n, res;
    op_busy = 2; fail_flag = 1'b0;
    issue(2'd0, 24'h123456, 12'd3);
    wait_done(res);
    chk(res == 0, "R2", "read result", res, 0);
    chk_log(b + 0, 0, 8'h00, "R2"); chk_log(b + 1, 1, 8'h03, "R2");
    chk_log(b + 2, 1, 8'h00, "R2"); chk_log(b + 3, 1, 8'h56, "R2");
    chk_log(b + 4, 1, 8'h34, "R2"); chk_log(b + 5, 1, 8'h12, "R2");
    chk_log(b + 6, 0, 8'h30, "R2"); chk_log(b + 7, 0, 8'h70, "R5");
    chk_log(b + 8, 0, 8'h00, "R2");
    chk(log_n == b + 9, "R2", "read bus count", log_n - b, 9);
    chk(rq_n - r0 == TOT - 3, "R2", "read byte count", rq_n - r0, TOT - 3);
    for (int k = 0; k < TOT - 3; k++)
      chk(rq[8'(r0 + k)] == pat(3 + k), "R2", "read byte", rq[8'(r0 + k)], pat(3 + k));
  endtask

  task automatic t_program_stall();
    int b = log_n, w0 = wq_n, res;
    op_busy = 1; fail_flag = 1'b0; busy_left = 0;
    issue(2'd1, 24'h000008, 12'd0);
    repeat (300) @(negedge clk);
    chk(log_n - b == 7 && busy, "R10", "no data strobe while empty", log_n - b, 7);
    for (int k = 0; k < TOT; k++) wq[8'(w0 + k)] = 8'(k * 29 + 3);
    wq_n = w0 + TOT;
    wait_done(res);
    chk(res == 0, "R3", "program result", res, 0);
    chk_log(b + 0, 0, 8'h70, "R7"); chk_log(b + 1, 0, 8'h80, "R3");
    chk_log(b + 2, 1, 8'h00, "R3"); chk_log(b + 3, 1, 8'h00, "R3");
    chk_log(b + 4, 1, 8'h08, "R3"); chk_log(b + 5, 1, 8'h00, "R3");
    chk_log(b + 6, 1, 8'h00, "R3");
    for (int k = 0; k < TOT; k++) chk_log(b + 7 + k, 2, int'(8'(k * 29 + 3)), "R3");
    chk_log(b + 7 + TOT, 0, 8'h10, "R3");
    chk_log(b + 8 + TOT, 0, 8'h70, "R5");
  endtask

  task automatic t_erase_fail();
    int b = log_n, res;
    op_busy = 0; fail_flag = 1'b1; busy_left = 0;
    issue(2'd2, 24'h00000C, 12'd0);
    wait_done(res);
    chk(res == 1, "R5", "erase fail result", res, 1);
    chk_log(b + 0, 0, 8'h70, "R7"); chk_log(b + 1, 0, 8'h60, "R4");
    chk_log(b + 2, 1, 8'h0C, "R4"); chk_log(b + 3, 1, 8'h00, "R4");
    chk_log(b + 4, 1, 8'h00, "R4"); chk_log(b + 5, 0, 8'hD0, "R4");
    chk_log(b + 6, 0, 8'h70, "R5");
    chk(log_n == b + 7, "R4", "erase bus count", log_n - b, 7);
    fail_flag = 1'b0;
  endtask

  task automatic t_reject_one(input logic [1:0] o, input logic [23:0] p, input logic [11:0] c);
    int b = log_n, res;
    issue(o, p, c);
    wait_done(res);
    chk(res == 3, "R1", "reject result", res, 3);
    chk(log_n == b && ce_n === 1'b1, "R1", "reject bus quiet", log_n - b, 0);
  endtask

  task automatic t_timeout();
    int b = log_n, s0, res;
    op_busy = 100;
    issue(2'd0, 24'h000001, 12'd0);
    @(negedge clk);
    s0 = re_stat;
    wait_done(res);
    chk(res == 2, "R6", "timeout result", res, 2);
    chk(re_stat - s0 == PMAX, "R6", "status reads", re_stat - s0, PMAX);
    chk(log_n == b + 8, "R6", "no bus after timeout", log_n - b, 8);
    busy_left = 0; op_busy = 0;
  endtask

  task automatic t_precheck();
    int b = log_n, res;
    op_busy = 0; busy_left = PMAX + 1;
    issue(2'd2, 24'h000000, 12'd0);
    wait_done(res);
    chk(res == 0, "R7", "precheck recover result", res, 0);
    chk_log(b + 0, 0, 8'h70, "R7"); chk_log(b + 1, 0, 8'hFF, "R7");
    chk_log(b + 2, 0, 8'h70, "R7"); chk_log(b + 3, 0, 8'h60, "R7");
    b = log_n; busy_left = 50;
    issue(2'd1, 24'h000010, 12'd0);
    wait_done(res);
    chk(res == 2, "R7", "precheck timeout result", res, 2);
    chk(log_n == b + 3, "R7", "no program after precheck fail", log_n - b, 3);
    chk_log(b + 1, 0, 8'hFF, "R7");
    busy_left = 0;
  endtask

  task automatic t_busy_ignore();
    int b = log_n, r0 = rq_n, res, bad = 0;
    op_busy = 3;
    issue(2'd0, 24'h000001, 12'd0);
    repeat (20) @(negedge clk);
    chk(busy === 1'b1 && ce_n === 1'b0, "R9", "ce low while busy", {busy, ce_n}, 2'b10);
    op = 2'd2; page = 24'h0; col = 12'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done(res);
    for (int i = b; i < log_n; i++) if (log_k[i[9:0]] == 0 && log_b[i[9:0]] == 8'h60) bad++;
    chk(bad == 0 && res == 0, "R9", "start ignored while busy", bad, 0);
    chk(rq_n - r0 == TOT, "R9", "read completed", rq_n - r0, TOT);
    @(negedge clk);
    chk(ce_n === 1'b1 && busy === 1'b0, "R9", "ce released", {ce_n, busy}, 2'b10);
  endtask

  task automatic t_read_stall();
    int r0 = rq_n, res;
    op_busy = 0; rd_full = 1'b1;
    issue(2'd0, 24'h000002, 12'd16);
    repeat (300) @(negedge clk);
    chk(rq_n == r0 && busy, "R10", "no read strobe while full", rq_n - r0, 0);
    rd_full = 1'b0;
    wait_done(res);
    chk(res == 0 && rq_n - r0 == 4, "R10", "read after stall", rq_n - r0, 4);
    for (int k = 0; k < 4; k++)
      chk(rq[8'(r0 + k)] == pat(16 + k), "R10", "stalled read byte",
          rq[8'(r0 + k)], pat(16 + k));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_read();
    t_program_stall();
    t_erase_fail();
    t_reject_one(2'd2, 24'h000005, 12'd0);
    t_reject_one(2'd2, 24'h000004, 12'd1);
    t_reject_one(2'd1, 24'h000004, 12'd1);
    t_reject_one(2'd0, 24'h000004, 12'(TOT));
    t_reject_one(2'd3, 24'h000000, 12'd0);
    t_timeout();
    t_precheck();
    t_busy_ignore();
    t_read_stall();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule